// File: doc/BRIEF.md
# Edge-Detecting Clock-Crossing Synchronizer

This block takes a single-bit level, or a slow pulse held for several destination cycles, from a register in an unrelated clock domain. It brings that bit into the destination clock domain. The bit first settles through a chain of back-to-back flip-flops. The resolved value is offered as a level output. One more register keeps the previous resolved value. Comparing the two gives a pulse exactly one destination cycle wide for each qualifying transition.

Elaboration parameters configure the block:
- which transitions qualify: rising only, falling only, or both;
- whether the pulse is active high or active low;
- the idle value that reset loads into every stage;
- the depth of the settling chain.

A typical use is an interrupt line, a done flag or a slow strobe from another domain. Such a signal must be seen once and only once by destination logic.

Top module: `edge_sync`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, every stage is loaded with IDLE_LEVEL. After that edge `level_out` equals IDLE_LEVEL and `pulse_out` is inactive: 0 when PULSE_ACTIVE_LOW is 0, 1 when it is 1.
- R2: A change of `async_in` made between two destination edges appears on `level_out` right after the second rising `clk` edge that follows it (SYNC_STAGES = 2).
- R3: With EDGE_MODE = EDGE_RISE (encoding 0), each 0-to-1 transition of the resolved level gives one active `pulse_out` cycle. That cycle is the first one in which `level_out` shows the new value. Falling transitions give no pulse.
- R4: With EDGE_MODE = EDGE_FALL (encoding 1), each 1-to-0 transition of the resolved level gives one active `pulse_out` cycle, in the first cycle with the new level. Rising transitions give no pulse.
- R5: With EDGE_MODE = EDGE_BOTH (encoding 2), each transition in either direction gives one active `pulse_out` cycle, in the first cycle with the new level.
- R6: With PULSE_ACTIVE_LOW = 1, `pulse_out` idles at 1 and drops to 0 for the single pulse cycle.
- R7: An input held at a new value for any length of time gives one pulse only. No further pulse appears until the input changes again.
- R8: Releasing reset while `async_in` is at IDLE_LEVEL produces no pulse.
- R9: When `async_in` is toggled from an unrelated clock and each level is held for more than two destination periods, each held level gives exactly one pulse (EDGE_BOTH). The pulse comes within three destination cycles of the transition, and `level_out` then matches the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Destination-domain clock |
| rst | input | 1 | Synchronous active-high reset, destination domain |
| async_in | input | 1 | Bit from a source-domain register, asynchronous to `clk` |
| level_out | output | 1 | Resolved level in the destination domain |
| pulse_out | output | 1 | One-cycle pulse on each qualifying transition |

## Verification
A wrong value in the settling chain shows on `level_out` within the chain depth, two destination cycles. The matching pulse then shows up shifted, missing or doubled. A history register stuck or loaded with the wrong idle value causes either a pulse just after reset release or a pulse that repeats or never ends. This shows on `pulse_out` in the first cycle after the fault. A wrong edge decode or polarity shows on the first qualifying transition. The bench therefore runs the same input through four configurations and samples each output cycle by cycle around every transition.

// File: rtl/edge_sync_pkg.sv
package edge_sync_pkg;
   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_BOTH = 2'd2
   } edge_mode_e;

   localparam int MIN_STAGES = 2;
   localparam int MAX_STAGES = 4;
endpackage

// File: rtl/edge_sync_chain.sv
module edge_sync_chain #(
   parameter int   STAGES     = 2,
   parameter logic IDLE_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d_async,
   output logic q_sync
);
   localparam int TOP = STAGES - 1;

   logic [TOP:0] stage_q;

   always_ff @(posedge clk) begin
      if (rst) stage_q <= {STAGES{IDLE_LEVEL}};
      else     stage_q <= {stage_q[TOP-1:0], d_async};
   end

   assign q_sync = stage_q[TOP];

   // R1: reset loads the idle value into the resolved output
   assert_reset_idle_R1: assert property (@(posedge clk)
      rst |=> (q_sync == IDLE_LEVEL));
endmodule

// File: rtl/edge_sync_detect.sv
module edge_sync_detect
   import edge_sync_pkg::*;
#(
   parameter edge_mode_e EDGE_MODE        = EDGE_RISE,
   parameter logic       PULSE_ACTIVE_LOW = 1'b0,
   parameter logic       IDLE_LEVEL       = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic lvl,
   output logic hit,
   output logic pulse
);
   logic hist_q;

   always_ff @(posedge clk) begin
      if (rst) hist_q <= IDLE_LEVEL;
      else     hist_q <= lvl;
   end

   generate
      if (EDGE_MODE == EDGE_RISE) begin : g_rise
         assign hit = lvl & ~hist_q;
      end else if (EDGE_MODE == EDGE_FALL) begin : g_fall
         assign hit = ~lvl & hist_q;
      end else begin : g_both
         assign hit = lvl ^ hist_q;
      end

      if (PULSE_ACTIVE_LOW) begin : g_low
         assign pulse = ~hit;
      end else begin : g_high
         assign pulse = hit;
      end

      if (EDGE_MODE != EDGE_BOTH) begin : g_single_chk
         // R3 R4: a single-direction pulse never lasts two cycles
         assert_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
            hit |=> !hit);
      end
   endgenerate
endmodule

// File: rtl/edge_sync.sv
module edge_sync
   import edge_sync_pkg::*;
#(
   parameter edge_mode_e EDGE_MODE        = EDGE_RISE,
   parameter logic       PULSE_ACTIVE_LOW = 1'b0,
   parameter logic       IDLE_LEVEL       = 1'b0,
   parameter int         SYNC_STAGES      = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic level_out,
   output logic pulse_out
);
   initial begin
      assert (SYNC_STAGES >= MIN_STAGES && SYNC_STAGES <= MAX_STAGES)
         else $error("edge_sync: SYNC_STAGES out of range");
   end

   logic lvl_sync;
   logic hit;

   edge_sync_chain #(
      .STAGES    (SYNC_STAGES),
      .IDLE_LEVEL(IDLE_LEVEL)
   ) u_chain (
      .clk    (clk),
      .rst    (rst),
      .d_async(async_in),
      .q_sync (lvl_sync)
   );

   edge_sync_detect #(
      .EDGE_MODE       (EDGE_MODE),
      .PULSE_ACTIVE_LOW(PULSE_ACTIVE_LOW),
      .IDLE_LEVEL      (IDLE_LEVEL)
   ) u_detect (
      .clk  (clk),
      .rst  (rst),
      .lvl  (lvl_sync),
      .hit  (hit),
      .pulse(pulse_out)
   );

   assign level_out = lvl_sync;

   // R7: a pulse only accompanies a change of the resolved level
   assert_pulse_on_change_R7: assert property (@(posedge clk) disable iff (rst)
      hit |-> !$stable(lvl_sync));

   // R8: no pulse in the first cycle after reset release
   assert_quiet_release_R8: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> !hit);

   generate
      if (EDGE_MODE == EDGE_RISE) begin : g_a_rise
         // R3
         assert_rise_pulse_R3: assert property (@(posedge clk) disable iff (rst)
            $rose(lvl_sync) |-> hit);
      end else if (EDGE_MODE == EDGE_FALL) begin : g_a_fall
         // R4
         assert_fall_pulse_R4: assert property (@(posedge clk) disable iff (rst)
            $fell(lvl_sync) |-> hit);
      end else begin : g_a_both
         // R5
         assert_any_pulse_R5: assert property (@(posedge clk) disable iff (rst)
            !$stable(lvl_sync) |-> hit);
      end
   endgenerate
endmodule

// File: tb/edge_sync_bench.sv
`timescale 1ns/10ps
module edge_sync_bench;
   import edge_sync_pkg::*;

   logic clk = 1'b0;
   logic aclk = 1'b0;
   logic rst = 1'b1;
   logic din = 1'b0;
   logic lv_r, lv_f, lv_b, lv_l;
   logic p_r, p_f, p_b, p_l;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;
   always #3.65 aclk = ~aclk;

   edge_sync #(.EDGE_MODE(EDGE_RISE)) u_edge_sync (
      .clk(clk), .rst(rst), .async_in(din), .level_out(lv_r), .pulse_out(p_r));
   edge_sync #(.EDGE_MODE(EDGE_FALL)) u_fall (
      .clk(clk), .rst(rst), .async_in(din), .level_out(lv_f), .pulse_out(p_f));
   edge_sync #(.EDGE_MODE(EDGE_BOTH)) u_both (
      .clk(clk), .rst(rst), .async_in(din), .level_out(lv_b), .pulse_out(p_b));
   edge_sync #(.EDGE_MODE(EDGE_RISE), .PULSE_ACTIVE_LOW(1'b1)) u_low (
      .clk(clk), .rst(rst), .async_in(din), .level_out(lv_l), .pulse_out(p_l));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset;
      rst = 1'b1;
      din = 1'b0;
      repeat (3) tick();
      chk(lv_r == 1'b0, "R1 level", lv_r, 0);
      chk(p_r == 1'b0 && p_b == 1'b0, "R1 pulse high-active idle", p_r | p_b, 0);
      chk(p_l == 1'b1, "R1 active-low idle", p_l, 1);
      rst = 1'b0;
      for (int i = 0; i < 4; i++) begin
         tick();
         chk(p_r == 0 && p_f == 0 && p_b == 0 && p_l == 1, "R8 no pulse after release",
             {p_r, p_f, p_b, p_l}, 1);
      end
   endtask

   task automatic t_rise;
      din = 1'b1;
      tick();
      chk(lv_r == 1'b0, "R2 level after one edge", lv_r, 0);
      chk(p_r == 1'b0, "R2 no early pulse", p_r, 0);
      tick();
      chk(lv_r == 1'b1, "R2 level after two edges", lv_r, 1);
      chk(p_r == 1'b1, "R3 rise pulse", p_r, 1);
      chk(p_b == 1'b1, "R5 both pulse on rise", p_b, 1);
      chk(p_f == 1'b0, "R4 fall ignores rise", p_f, 0);
      chk(p_l == 1'b0, "R6 active-low pulse", p_l, 0);
      tick();
      chk(p_r == 1'b0 && p_b == 1'b0, "R3 pulse one cycle", p_r | p_b, 0);
      chk(p_l == 1'b1, "R6 active-low returns high", p_l, 1);
      for (int i = 0; i < 12; i++) begin
         tick();
         chk(p_r == 0 && p_b == 0 && p_f == 0, "R7 held level no repeat",
             {p_r, p_b, p_f}, 0);
      end
   endtask

   task automatic t_fall;
      din = 1'b0;
      tick();
      chk(lv_f == 1'b1, "R2 level holds after one edge", lv_f, 1);
      tick();
      chk(lv_f == 1'b0, "R2 level falls after two edges", lv_f, 0);
      chk(p_f == 1'b1, "R4 fall pulse", p_f, 1);
      chk(p_b == 1'b1, "R5 both pulse on fall", p_b, 1);
      chk(p_r == 1'b0, "R3 rise ignores fall", p_r, 0);
      chk(p_l == 1'b1, "R6 active-low ignores fall", p_l, 1);
      tick();
      chk(p_f == 1'b0 && p_b == 1'b0, "R4 pulse one cycle", p_f | p_b, 0);
      for (int i = 0; i < 12; i++) begin
         tick();
         chk(p_f == 0 && p_b == 0, "R7 held low no repeat", p_f | p_b, 0);
      end
   endtask

   task automatic t_async;
      for (int n = 0; n < 24; n++) begin
         int early;
         int late;
         int rises;
         early = 0; late = 0; rises = 0;
         @(posedge aclk);
         din = ~din;
         for (int k = 0; k < 6; k++) begin
            tick();
            if (k < 3) early += int'(p_b);
            else       late  += int'(p_b);
            rises += int'(p_r);
         end
         chk(early == 1, "R9 one pulse within three cycles", early, 1);
         chk(late == 0, "R9 no later pulse", late, 0);
         chk(rises == int'(din), "R9 rise-only count", rises, int'(din));
         chk(lv_b == din, "R9 level matches input", lv_b, din);
      end
   endtask

   initial begin
      t_reset();
      t_rise();
      t_fall();
      t_async();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule